// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the timing engine of a master on a single open-drain data line with a pull-up. It runs one bus operation per request: a bus reset followed by a listen for a slave's presence response, the write of a single bit, or the read of a single bit. All pulse widths, the sample points and the recovery gap are generated in hardware. The time base is a microsecond tick made from the system clock by a parameterised divider.

A client puts an operation code and a write bit on the inputs and raises `start` for one clock while the block is idle. `busy` rises on the next edge. When the operation and its recovery gap have finished, `done` pulses for one clock and `rd_result` holds either the presence flag or the bit that was read. The pad is modelled as an active-high pull-down enable (`line_drive_low`) plus the level seen on the line (`line_in`). That level passes through a two-flop synchroniser before it is sampled. Read bits are sampled near the end of the slave's valid window to leave the most margin.

Top module: `swire_master`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `line_drive_low` are all 0 and stay 0 until a request is made.
- R2: The operation codes are 2'b00 bus reset, 2'b01 write bit and 2'b10 read bit. A `start` with one of these codes while idle makes `busy` and `line_drive_low` high from the next clock edge.
- R3: A bus reset holds the line low for exactly T_RST_LOW microseconds (default 480), then releases it.
- R4: During a bus reset, the line level is sampled T_PRES_SMP microseconds (default 70) after release. `rd_result` is 1 if the line was low then (a slave is present) and 0 otherwise. The line stays released for T_RST_WAIT microseconds (default 480) after release.
- R5: A write with `wr_bit`=1 drives the line low for T_W1_LOW microseconds (default 2) and then releases it. The slot lasts T_SLOT microseconds (default 60).
- R6: A write with `wr_bit`=0 drives the line low for T_W0_LOW microseconds (default 60), which is the whole slot.
- R7: A read drives the line low for T_RD_LOW microseconds (default 2) and then releases it. The line is sampled T_RD_SMP microseconds (default 13) after the slot start, and `rd_result` equals the level sampled: low gives 0, high gives 1.
- R8: Every operation ends with T_REC microseconds (default 5) of released line before `done`. `busy` is therefore high for exactly (operation length + T_REC) microseconds.
- R9: `done` is a single-clock pulse. `busy` falls on the same edge on which `done` rises, and `rd_result` is valid while `done` is high.
- R10: A `start` while `busy` is high is ignored. The running operation keeps its timing and produces exactly one `done`.
- R11: The code 2'b11 is not an operation. A `start` carrying it leaves `busy`, `done` and `line_drive_low` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request strobe |
| op | input | 2 | Operation code (see R2) |
| wr_bit | input | 1 | Bit to send in a write slot |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-clock completion pulse |
| rd_result | output | 1 | Presence flag or bit read |
| line_drive_low | output | 1 | Pull-down enable for the open-drain pad |
| line_in | input | 1 | Level seen on the bus line |

## Verification
The bench measures every low pulse and every busy window in clock cycles. A divider that is off by one, or a counter that compares against the wrong limit, therefore shows up as a width error. Reads are run against a slave that releases at 14 µs and at 11 µs. A sample placed too early returns 0 in both cases, and a sample placed too late returns 1 in both. A write-zero whose low time equals the slot length is tested because a design that leaves the low phase and then waits for a slot end it has already reached would hang. Presence is checked with and without a responding slave, and requests that arrive mid-operation or carry the unused code are checked for any effect on the line, `busy` or `done`.

// File: rtl/swire_pkg.sv
package swire_pkg;

    localparam int US_W = 16;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_REC
    } st_e;

    // Per-operation timing plan, all in microseconds from operation start
    typedef struct packed {
        logic [US_W-1:0] low_us;
        logic [US_W-1:0] smp_us;
        logic [US_W-1:0] end_us;
        logic            smp_en;
        logic            smp_inv;
    } slot_t;

    function automatic slot_t plan_slot(
        input op_e  code,
        input logic wbit,
        input int   rst_low,
        input int   rst_wait,
        input int   pres_smp,
        input int   w1_low,
        input int   w0_low,
        input int   rd_low,
        input int   rd_smp,
        input int   slot_len
    );
        slot_t s;
        s = '0;
        case (code)
            OP_RESET: begin
                s.low_us  = US_W'(rst_low);
                s.smp_us  = US_W'(rst_low + pres_smp);
                s.end_us  = US_W'(rst_low + rst_wait);
                s.smp_en  = 1'b1;
                s.smp_inv = 1'b1;
            end
            OP_WRITE: begin
                s.low_us  = wbit ? US_W'(w1_low) : US_W'(w0_low);
                s.end_us  = US_W'(slot_len);
            end
            OP_READ: begin
                s.low_us  = US_W'(rd_low);
                s.smp_us  = US_W'(rd_smp);
                s.end_us  = US_W'(slot_len);
                s.smp_en  = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/swire_tick.sv
module swire_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end
endmodule

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= d;
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[i] <= 1'b1;
                end else begin
                    chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swire_engine.sv
module swire_engine
    import swire_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_RST_WAIT = 480,
    parameter int T_PRES_SMP = 70,
    parameter int T_W1_LOW   = 2,
    parameter int T_W0_LOW   = 60,
    parameter int T_RD_LOW   = 2,
    parameter int T_RD_SMP   = 13,
    parameter int T_SLOT     = 60,
    parameter int T_REC      = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       wr_bit,
    input  logic       line_s,
    output logic       tick_clr,
    output logic       drive_low,
    output logic       busy,
    output logic       done,
    output logic       result
);
    localparam logic [US_W-1:0] REC_US = US_W'(T_REC);

    st_e             state_q;
    slot_t           slot_q;
    logic [US_W-1:0] cnt_q;
    logic [US_W-1:0] cnt_nx;
    logic            res_q;
    logic            done_q;
    logic            accept;
    slot_t           slot_n;

    assign accept   = start && (state_q == ST_IDLE) && (op != 2'(OP_NONE));
    assign tick_clr = accept;
    assign cnt_nx   = cnt_q + US_W'(1);

    always_comb begin
        slot_n = plan_slot(op_e'(op), wr_bit, T_RST_LOW, T_RST_WAIT, T_PRES_SMP,
                           T_W1_LOW, T_W0_LOW, T_RD_LOW, T_RD_SMP, T_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cnt_q   <= '0;
            res_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        slot_q  <= slot_n;
                        cnt_q   <= '0;
                        res_q   <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (cnt_nx == slot_q.low_us) begin
                            if (cnt_nx == slot_q.end_us) begin
                                cnt_q   <= '0;
                                state_q <= ST_REC;
                            end else begin
                                state_q <= ST_HIGH;
                            end
                        end
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (slot_q.smp_en && (cnt_nx == slot_q.smp_us)) begin
                            res_q <= line_s ^ slot_q.smp_inv;
                        end
                        if (cnt_nx == slot_q.end_us) begin
                            cnt_q   <= '0;
                            state_q <= ST_REC;
                        end
                    end
                end
                ST_REC: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (cnt_nx == REC_US) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign drive_low = (state_q == ST_LOW);
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign result    = res_q;

    // R9: completion strobe lasts one clock
    p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: completion only on the way out of recovery
    p_done_after_rec_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == ST_IDLE) && ($past(state_q) == ST_REC));

    // R2: an accepted request pulls the line on the next edge
    p_accept_drives_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> drive_low && busy);

    // R10: a request during an operation leaves the timing plan untouched
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && start |=> $stable(slot_q));

    // R11: the unused code never starts anything
    p_bad_op_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) && start && (op == 2'b11) |=> (state_q == ST_IDLE) && !drive_low);

    // R8: recovery keeps the line released
    p_rec_released_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REC) |-> !drive_low);
endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter int CLK_PER_US  = 250,
    parameter int SYNC_STAGES = 2,
    parameter int T_RST_LOW   = 480,
    parameter int T_RST_WAIT  = 480,
    parameter int T_PRES_SMP  = 70,
    parameter int T_W1_LOW    = 2,
    parameter int T_W0_LOW    = 60,
    parameter int T_RD_LOW    = 2,
    parameter int T_RD_SMP    = 13,
    parameter int T_SLOT      = 60,
    parameter int T_REC       = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       wr_bit,
    output logic       busy,
    output logic       done,
    output logic       rd_result,
    output logic       line_drive_low,
    input  logic       line_in
);
    logic tick;
    logic tick_clr;
    logic line_s;

    swire_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .tick (tick)
    );

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_s)
    );

    swire_engine #(
        .T_RST_LOW  (T_RST_LOW),
        .T_RST_WAIT (T_RST_WAIT),
        .T_PRES_SMP (T_PRES_SMP),
        .T_W1_LOW   (T_W1_LOW),
        .T_W0_LOW   (T_W0_LOW),
        .T_RD_LOW   (T_RD_LOW),
        .T_RD_SMP   (T_RD_SMP),
        .T_SLOT     (T_SLOT),
        .T_REC      (T_REC)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .op        (op),
        .wr_bit    (wr_bit),
        .line_s    (line_s),
        .tick_clr  (tick_clr),
        .drive_low (line_drive_low),
        .busy      (busy),
        .done      (done),
        .result    (rd_result)
    );

    // R1/R9: the line is only pulled while an operation runs
    p_drive_within_busy_r2: assert property (@(posedge clk) disable iff (rst)
        line_drive_low |-> busy);

    // R9: busy drops exactly as done rises
    p_busy_ends_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy && $past(busy));
endmodule

// File: tb/test_swire_master.sv
`timescale 1ns/1ps
module test_swire_master;
    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic       wr_bit = 1'b0;
    logic       busy, done, rd_result, line_drive_low;
    logic       line_in;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // slave model controls
    int  mode = 0;          // 0 silent, 1 presence responder, 2 read-zero holder
    int  pres_from = 0;
    int  pres_to = 0;
    int  hold_cyc = 0;
    logic dl_q = 1'b0;
    int  since_fall = 1000000;
    int  since_rise = 1000000;
    logic slave_low;

    always #2 clk = ~clk;

    swire_master #(.CLK_PER_US(CPU)) i_swire_master (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .op             (op),
        .wr_bit         (wr_bit),
        .busy           (busy),
        .done           (done),
        .rd_result      (rd_result),
        .line_drive_low (line_drive_low),
        .line_in        (line_in)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        dl_q <= line_drive_low;
        if (line_drive_low && !dl_q) since_rise <= 0; else since_rise <= since_rise + 1;
        if (!line_drive_low && dl_q) since_fall <= 0; else since_fall <= since_fall + 1;
    end

    assign slave_low = (mode == 1) ? (since_fall >= pres_from && since_fall < pres_to) :
                       (mode == 2) ? (since_rise < hold_cyc) : 1'b0;
    assign line_in = !(line_drive_low || slave_low);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one request and measure it; poke>0 raises a stray start that many cycles in
    task automatic run_op(input logic [1:0] code, input logic b, input int poke,
                          output int low_c, output int busy_c, output int res, output int ndone);
        int n;
        bit seen;
        low_c = 0; busy_c = 0; res = -1; ndone = 0; seen = 0;
        @(negedge clk);
        op = code; wr_bit = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (n = 0; n < 20000 && !seen; n++) begin
            if (line_drive_low) low_c++;
            if (busy) busy_c++;
            if (done) begin
                ndone++; res = int'(rd_result); seen = 1;
                check(!busy, "R9 busy low with done", int'(busy), 0);
            end
            if (poke > 0 && n == poke) begin
                op = 2'b10; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (!seen) @(negedge clk);
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) ndone++;
        end
    endtask

    task automatic t_reset_state();
        check(!busy, "R1 busy after reset", int'(busy), 0);
        check(!done, "R1 done after reset", int'(done), 0);
        check(!line_drive_low, "R1 line after reset", int'(line_drive_low), 0);
    endtask

    task automatic t_bus_reset(input bit present);
        int lc, bc, r, nd;
        mode = present ? 1 : 0; pres_from = 30*CPU; pres_to = 150*CPU;
        run_op(2'b00, 1'b0, 0, lc, bc, r, nd);
        check(lc == 480*CPU, "R3 reset low width", lc, 480*CPU);
        check(bc == (960+5)*CPU, "R4 R8 reset busy span", bc, (960+5)*CPU);
        check(r == int'(present), "R4 presence flag", r, int'(present));
        check(nd == 1, "R9 single done", nd, 1);
        mode = 0;
    endtask

    task automatic t_write(input logic b);
        int lc, bc, r, nd, exp_l;
        exp_l = b ? 2*CPU : 60*CPU;
        run_op(2'b01, b, 0, lc, bc, r, nd);
        check(lc == exp_l, b ? "R5 write-one low" : "R6 write-zero low", lc, exp_l);
        check(bc == 65*CPU, "R5 R8 write slot span", bc, 65*CPU);
        check(nd == 1, "R9 single done", nd, 1);
    endtask

    task automatic t_read(input int hold_us, input int exp);
        int lc, bc, r, nd;
        mode = (hold_us > 0) ? 2 : 0; hold_cyc = hold_us*CPU;
        run_op(2'b10, 1'b0, 0, lc, bc, r, nd);
        check(lc == 2*CPU, "R7 read init low", lc, 2*CPU);
        check(r == exp, "R7 read sample", r, exp);
        check(bc == 65*CPU, "R7 R8 read slot span", bc, 65*CPU);
        mode = 0;
    endtask

    task automatic t_busy_start();
        int lc, bc, r, nd;
        run_op(2'b01, 1'b0, 20, lc, bc, r, nd);
        check(lc == 60*CPU, "R10 low width kept", lc, 60*CPU);
        check(bc == 65*CPU, "R10 span kept", bc, 65*CPU);
        check(nd == 1, "R10 one done", nd, 1);
        repeat (3) @(negedge clk);
        check(!busy, "R10 no second op", int'(busy), 0);
    endtask

    task automatic t_bad_op();
        int hits;
        hits = 0;
        @(negedge clk);
        op = 2'b11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (busy || done || line_drive_low) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R11 unused code ignored", hits, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_bus_reset(1'b1);
        t_bus_reset(1'b0);
        t_write(1'b1);
        t_write(1'b0);
        t_read(14, 0);
        t_read(11, 1);
        t_read(0, 1);
        t_busy_start();
        t_bad_op();
        t_write(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule